// File: doc/BRIEF.md
# Masked External Interrupt Priority Selector

This block gathers a bank of level-sensitive external interrupt lines and presents them to a processor through its machine-mode CSR port. Software writes a per-line enable mask. It can read the raw line state from a pending register that ignores the mask. It can also read a priority index. The index names the lowest-numbered line that is both high and enabled, multiplied by four, so a handler can use it directly as a byte offset into a table of word-sized vectors.

The block drives the machine external-interrupt-pending bit that the core's trap logic consumes. It combines that bit with the core's external-interrupt enable and its global interrupt enable to say whether an interrupt is taken now. When an interrupt is taken, it supplies the trap cause value.

Peripherals hold their lines high until software services them. A handler therefore samples the index once on entry, clears the source through the peripheral, and returns. If further lines are still enabled and high, the handler is entered again.

Top module: `ext_irq_sel`

## Requirements
- R1: After reset the enable mask is all zeros: a read of the mask address returns 0 and `meip` is low even with every line high.
- R2: A read of the pending address (default 0xFE0) returns the input lines as sampled at the previous clock edge, one bit per line with line k in bit k, whatever the mask holds.
- R3: A write strobe at the mask address (default 0xBE0) loads `csr_wdata` into the mask at that clock edge, and later reads of that address return it; bit k enables line k.
- R4: When several lines are both high and enabled, the selected line is the lowest-numbered one.
- R5: A read of the index address (default 0xFE4) returns the selected line number times 4 (line 0 reads 0, line 31 reads 124).
- R6: `meip` is high in a cycle exactly when some registered line is both high and enabled by the current mask, so it follows a line change one cycle after the edge that samples it.
- R7: Setting a mask bit for a line that is already high raises `meip` in the cycle after the write, with no new edge on the line.
- R8: When no line is both high and enabled, `sel_valid` and `meip` are low and the index reads 0.
- R9: `irq_take` is high exactly when `meip`, `core_meie` and `core_gie` are all high.
- R10: `trap_cause` is 0x8000000B (interrupt flag in bit 31, code 11) while `irq_take` is high, and 0 otherwise.
- R11: Writes to the pending and index addresses change neither the mask nor what those addresses read back. A read of any address other than the three above returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 32 | Level-sensitive external interrupt lines |
| csr_addr | input | 12 | CSR address |
| csr_wdata | input | 32 | CSR write data |
| csr_wen | input | 1 | CSR write strobe |
| csr_rdata | output | 32 | CSR read data for `csr_addr`, combinational |
| core_meie | input | 1 | Core machine external interrupt enable |
| core_gie | input | 1 | Core global machine interrupt enable |
| meip | output | 1 | Machine external interrupt pending |
| sel_valid | output | 1 | A line is both high and enabled |
| irq_take | output | 1 | External interrupt is taken this cycle |
| trap_cause | output | 32 | Trap cause value while taken, else 0 |

## Verification
Every internal state bit of the block reaches the ports within one cycle. A corrupted mask bit or a stale registered line therefore appears as a wrong `meip`, a wrong index or a wrong pending read in the very cycle it exists. For this reason, a behavioural model is compared against all outputs on every clock.

The stimulus covers three service patterns:
- every line high while the mask opens one line at a time from the top;
- the mask fully open while single lines arrive in turn;
- all lines firing together and being cleared lowest first.

These patterns catch a wrong priority direction, wrong scaling of the index, and a request that waits for an edge. Writes to the read-only addresses and toggling of the core enables check that nothing else leaks into the state.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
    localparam logic [11:0] ADDR_MASK_DEF = 12'hBE0;
    localparam logic [11:0] ADDR_PEND_DEF = 12'hFE0;
    localparam logic [11:0] ADDR_IDX_DEF  = 12'hFE4;
    localparam logic [31:0] CAUSE_EXT     = 32'h8000_000B;
endpackage

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
    parameter int N     = 32,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     req,
    output logic             valid,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        valid = 1'b0;
        idx   = '0;
        // Scan downward so the lowest set bit is written last and wins.
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                valid = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/irq_csr_mux.sv
module irq_csr_mux #(
    parameter int          N         = 32,
    parameter int          XLEN      = 32,
    parameter int          ADDR_W    = 12,
    parameter int          SCALED_W  = 7,
    parameter logic [11:0] ADDR_MASK = 12'hBE0,
    parameter logic [11:0] ADDR_PEND = 12'hFE0,
    parameter logic [11:0] ADDR_IDX  = 12'hFE4
) (
    input  logic [ADDR_W-1:0]   addr,
    input  logic [N-1:0]        mask,
    input  logic [N-1:0]        lines,
    input  logic [SCALED_W-1:0] idx_scaled,
    output logic [XLEN-1:0]     rdata
);
    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(ADDR_MASK))      rdata = XLEN'(mask);
        else if (addr == ADDR_W'(ADDR_PEND)) rdata = XLEN'(lines);
        else if (addr == ADDR_W'(ADDR_IDX))  rdata = XLEN'(idx_scaled);
    end
endmodule

// File: rtl/ext_irq_sel.sv
module ext_irq_sel
    import ext_irq_pkg::*;
#(
    parameter int          NUM_LINES = 32,
    parameter int          XLEN      = 32,
    parameter int          ADDR_W    = 12,
    parameter logic [11:0] ADDR_MASK = ADDR_MASK_DEF,
    parameter logic [11:0] ADDR_PEND = ADDR_PEND_DEF,
    parameter logic [11:0] ADDR_IDX  = ADDR_IDX_DEF
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] irq_in,
    input  logic [ADDR_W-1:0]    csr_addr,
    input  logic [XLEN-1:0]      csr_wdata,
    input  logic                 csr_wen,
    output logic [XLEN-1:0]      csr_rdata,
    input  logic                 core_meie,
    input  logic                 core_gie,
    output logic                 meip,
    output logic                 sel_valid,
    output logic                 irq_take,
    output logic [XLEN-1:0]      trap_cause
);
    localparam int IDX_W    = $clog2(NUM_LINES);
    localparam int SCALED_W = IDX_W + 2;

    typedef struct packed {
        logic [NUM_LINES-1:0] mask;
        logic [NUM_LINES-1:0] lines;
    } state_t;

    state_t state_d, state_q;

    logic [NUM_LINES-1:0] req;
    logic [IDX_W-1:0]     win_idx;
    logic [SCALED_W-1:0]  idx_scaled;

    always_comb begin
        state_d       = state_q;
        state_d.lines = irq_in;
        if (csr_wen && csr_addr == ADDR_W'(ADDR_MASK)) begin
            state_d.mask = csr_wdata[NUM_LINES-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q.mask  <= '0;
            state_q.lines <= irq_in;
        end else begin
            state_q <= state_d;
        end
    end

    assign req = state_q.lines & state_q.mask;

    irq_prio_enc #(.N(NUM_LINES), .IDX_W(IDX_W)) u_enc (
        .req   (req),
        .valid (sel_valid),
        .idx   (win_idx)
    );

    assign idx_scaled = sel_valid ? {win_idx, 2'b00} : '0;

    irq_csr_mux #(
        .N(NUM_LINES), .XLEN(XLEN), .ADDR_W(ADDR_W), .SCALED_W(SCALED_W),
        .ADDR_MASK(ADDR_MASK), .ADDR_PEND(ADDR_PEND), .ADDR_IDX(ADDR_IDX)
    ) u_mux (
        .addr       (csr_addr),
        .mask       (state_q.mask),
        .lines      (state_q.lines),
        .idx_scaled (idx_scaled),
        .rdata      (csr_rdata)
    );

    assign meip       = |req;
    assign irq_take   = meip & core_meie & core_gie;
    assign trap_cause = irq_take ? XLEN'(CAUSE_EXT) : '0;
endmodule

// File: rtl/ext_irq_sel_chk.sv
module ext_irq_sel_chk #(
    parameter int          N         = 32,
    parameter int          XLEN      = 32,
    parameter int          ADDR_W    = 12,
    parameter int          SCALED_W  = 7,
    parameter logic [11:0] ADDR_MASK = 12'hBE0,
    parameter logic [11:0] ADDR_PEND = 12'hFE0
) (
    input logic                clk,
    input logic                rst_n,
    input logic [N-1:0]        irq_in,
    input logic [ADDR_W-1:0]   csr_addr,
    input logic [XLEN-1:0]     csr_wdata,
    input logic                csr_wen,
    input logic [XLEN-1:0]     csr_rdata,
    input logic                core_meie,
    input logic                core_gie,
    input logic                meip,
    input logic                sel_valid,
    input logic                irq_take,
    input logic [XLEN-1:0]     trap_cause,
    input logic [N-1:0]        mask_q,
    input logic [N-1:0]        lines_q,
    input logic [SCALED_W-1:0] idx_scaled
);
    localparam int IDX_W = SCALED_W - 2;

    logic [N-1:0]     win_req;
    logic [IDX_W-1:0] widx;
    logic [N-1:0]     below;

    assign win_req = mask_q & lines_q;
    assign widx    = idx_scaled[SCALED_W-1:2];
    assign below   = win_req & ((N'(1) << widx) - N'(1));

    p_mask_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> mask_q == '0);

    p_pend_raw_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_addr == ADDR_W'(ADDR_PEND)) |-> csr_rdata == XLEN'($past(irq_in)));

    p_mask_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_wen && csr_addr == ADDR_W'(ADDR_MASK)) |=> mask_q == $past(csr_wdata[N-1:0]));

    p_lowest_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sel_valid |-> (win_req[widx] && below == '0));

    p_clear_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_wen && csr_addr == ADDR_W'(ADDR_MASK) && csr_wdata == '0) |=> !meip);

    p_idle_index_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_valid |-> (idx_scaled == '0 && !meip));

    p_take_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_take |-> (meip && core_meie && core_gie));

    p_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_take |-> trap_cause == '0);
endmodule

bind ext_irq_sel ext_irq_sel_chk #(
    .N(NUM_LINES), .XLEN(XLEN), .ADDR_W(ADDR_W), .SCALED_W(SCALED_W),
    .ADDR_MASK(ADDR_MASK), .ADDR_PEND(ADDR_PEND)
) u_chk (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .csr_addr(csr_addr),
    .csr_wdata(csr_wdata), .csr_wen(csr_wen), .csr_rdata(csr_rdata),
    .core_meie(core_meie), .core_gie(core_gie), .meip(meip),
    .sel_valid(sel_valid), .irq_take(irq_take), .trap_cause(trap_cause),
    .mask_q(state_q.mask), .lines_q(state_q.lines), .idx_scaled(idx_scaled)
);

// File: tb/tb_ext_irq_sel.sv
module tb_ext_irq_sel;
    localparam int          CLK_PERIOD = 10;
    localparam logic [11:0] A_MASK = 12'hBE0;
    localparam logic [11:0] A_PEND = 12'hFE0;
    localparam logic [11:0] A_IDX  = 12'hFE4;

    logic        clk = 0, rst_n = 0;
    logic [31:0] irq_in = '0, csr_wdata = '0;
    logic [11:0] csr_addr = '0;
    logic        csr_wen = 0, core_meie = 0, core_gie = 0;
    logic [31:0] csr_rdata, trap_cause;
    logic        meip, sel_valid, irq_take;

    int checks = 0, fails = 0;
    logic [31:0] m_mask, m_lines;
    bit          started = 0;

    ext_irq_sel dut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .csr_addr(csr_addr),
        .csr_wdata(csr_wdata), .csr_wen(csr_wen), .csr_rdata(csr_rdata),
        .core_meie(core_meie), .core_gie(core_gie), .meip(meip),
        .sel_valid(sel_valid), .irq_take(irq_take), .trap_cause(trap_cause)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference model
    always @(posedge clk) begin
        if (!rst_n) m_mask = '0;
        else if (csr_wen && csr_addr == A_MASK) m_mask = csr_wdata;
        m_lines = irq_in;
        started = 1;
    end

    function automatic int exp_idx(input logic [31:0] r);
        int e = 0;
        for (int i = 31; i >= 0; i--) if (r[i]) e = i * 4;
        return e;
    endfunction

    always @(negedge clk) begin
        if (started && rst_n) begin
            logic [31:0] r, rd;
            logic any, take;
            r    = m_mask & m_lines;
            any  = |r;
            take = any & core_meie & core_gie;
            chk("R6 meip", 32'(meip), 32'(any));
            chk("R8 sel_valid", 32'(sel_valid), 32'(any));
            chk("R9 irq_take", 32'(irq_take), 32'(take));
            chk("R10 trap_cause", trap_cause, take ? 32'h8000000B : 32'h0);
            if (csr_addr == A_MASK)      rd = m_mask;
            else if (csr_addr == A_PEND) rd = m_lines;
            else if (csr_addr == A_IDX)  rd = 32'(exp_idx(r));
            else                         rd = '0;
            chk("R2 R3 R4 R5 R11 csr_rdata", csr_rdata, rd);
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        csr_addr = a; csr_wdata = d; csr_wen = 1;
        step();
        csr_wen = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        irq_in = '1;
        repeat (3) step();
        rst_n = 1;
        csr_addr = A_MASK;
        step();
        @(negedge clk);
        chk("R1 mask after reset", csr_rdata, 32'h0);
        chk("R1 meip after reset", 32'(meip), 32'h0);

        // Every line high, open the mask one line at a time from the top.
        core_meie = 1; core_gie = 1;
        for (int i = 31; i >= 0; i--) begin
            wr(A_MASK, 32'h1 << i);
            csr_addr = A_IDX;
            @(negedge clk);
            chk("R7 meip on mask open", 32'(meip), 32'h1);
            chk("R5 index", csr_rdata, 32'(i * 4));
            csr_addr = A_PEND;
            #1;
            chk("R2 pending raw", csr_rdata, 32'hFFFF_FFFF >> (31 - i));
            irq_in[i] = 1'b0;
            step();
        end

        // Mask open, lines arrive one at a time.
        wr(A_MASK, 32'hFFFF_FFFF);
        csr_addr = A_IDX;
        for (int i = 0; i < 32; i++) begin
            irq_in = 32'h1 << i;
            step();
            @(negedge clk);
            chk("R5 single line index", csr_rdata, 32'(i * 4));
            irq_in = '0;
            step();
        end

        // All lines together, cleared lowest first.
        irq_in = '1;
        step();
        for (int i = 0; i < 32; i++) begin
            @(negedge clk);
            chk("R4 lowest first", csr_rdata, 32'(i * 4));
            irq_in[i] = 1'b0;
            step();
        end
        @(negedge clk);
        chk("R8 idle index", csr_rdata, 32'h0);

        // Read-only addresses ignore writes.
        wr(A_PEND, 32'hFFFF_FFFF);
        wr(A_IDX, 32'hFFFF_FFFF);
        csr_addr = A_PEND;
        @(negedge clk);
        chk("R11 pending unchanged", csr_rdata, 32'h0);
        csr_addr = A_MASK;
        #1;
        chk("R11 mask unchanged", csr_rdata, 32'hFFFF_FFFF);
        csr_addr = 12'h123;
        #1;
        chk("R11 other address", csr_rdata, 32'h0);

        // Core enables gate the take.
        irq_in = 32'h0000_0100;
        step();
        core_gie = 0;
        #1;
        chk("R9 gie low", 32'(irq_take), 32'h0);
        core_gie = 1; core_meie = 0;
        #1;
        chk("R9 meie low", 32'(irq_take), 32'h0);
        core_meie = 1;
        #1;
        chk("R10 cause", trap_cause, 32'h8000000B);
        step();

        // Masking everything with lines high.
        irq_in = '1;
        wr(A_MASK, 32'h0);
        @(negedge clk);
        chk("R8 masked meip", 32'(meip), 32'h0);
        wr(A_MASK, 32'h0000_0400);
        csr_addr = A_IDX;
        @(negedge clk);
        chk("R7 reopen index", csr_rdata, 32'd40);
        step();

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule